// File: doc/BRIEF.md
# Word/Byte Split Memory Port

This block connects a processor datapath to main memory through two ports that use different address units. The data port works on whole 32-bit words. It holds a word address register and a word data register. The instruction port works on bytes. It holds a byte address register and a one-byte instruction buffer. The datapath loads the three address and data registers from its result bus. Three command lines from the current microinstruction start a write, a read or an instruction fetch. Any two or all three of them may be raised in the same cycle.

A command raised in cycle N is registered. The matching memory strobe is driven in cycle N+1, using the register contents of that cycle. The word that comes back is captured at the end of N+1, so it is visible from cycle N+2. Until then the target register keeps its old value. The fetched byte is shown to the datapath in three forms: raw, zero-extended to 32 bits and sign-extended to 32 bits.

The memory side is a fixed-latency interface with no valid/ready handshake and no back-pressure. Memory must return read data combinationally in the same cycle as its strobe, and it must accept a write strobe in the cycle it appears. A slower memory would need a stall input, and this block has none.

Top module: `mbif_bridge`

## Requirements
- R1: After reset the word address, word data, byte address and byte buffer registers are all zero, and no memory strobe is active.
- R2: When `ld_mar`, `ld_mdr` or `ld_pc` is high at a clock edge, the matching register takes `c_bus` at that edge.
- R3: The data-port byte address `d_addr` is the word address register shifted left by two, with bits 1:0 zero. The top two bits of the register are dropped, so a word address of 3 gives byte address 12.
- R4: `cmd_rd` high in cycle N makes `d_re` high in cycle N+1. The word on `d_rdata` in N+1 appears on `mdr_q` from cycle N+2. `mdr_q` keeps its previous value through cycle N+1.
- R5: `cmd_wr` high in cycle N makes `d_we` high in cycle N+1. In that cycle `d_wdata` equals the word data register and `d_addr` follows R3.
- R6: `cmd_fetch` high in cycle N makes `i_re` high in cycle N+1, with `i_addr` equal to the byte address register with bits 1:0 cleared. The byte picked by byte-address bits 1:0 from `i_rdata` appears on `mbr_q` from cycle N+2. Lanes are little-endian: lane k is bits 8k+7:8k.
- R7: `mbr_zx` is `mbr_q` in bits 7:0, with bits 31:8 zero.
- R8: `mbr_sx` is `mbr_q` in bits 7:0, with bit 7 of `mbr_q` copied into bits 31:8.
- R9: When read and fetch commands are raised in the same cycle, both transfers complete with the timing of R4 and R6.
- R10: When a memory read result and `ld_mdr` arrive at the same edge, the memory word is stored and `c_bus` is ignored.
- R11: `mbr_q` changes only on an edge that ends an `i_re` cycle. `mdr_q` changes only on an edge with `ld_mdr` high or that ends a `d_re` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_bus | input | 32 | Datapath result bus |
| ld_mar | input | 1 | Load word address register from c_bus |
| ld_mdr | input | 1 | Load word data register from c_bus |
| ld_pc | input | 1 | Load byte address register from c_bus |
| cmd_wr | input | 1 | Start a word write |
| cmd_rd | input | 1 | Start a word read |
| cmd_fetch | input | 1 | Start a byte fetch |
| mar_q | output | 32 | Word address register |
| mdr_q | output | 32 | Word data register |
| pc_q | output | 32 | Byte address register |
| mbr_q | output | 8 | Fetched byte buffer |
| mbr_zx | output | 32 | Buffer, zero-extended |
| mbr_sx | output | 32 | Buffer, sign-extended |
| d_addr | output | 32 | Data-port byte address |
| d_re | output | 1 | Data-port read strobe |
| d_we | output | 1 | Data-port write strobe |
| d_wdata | output | 32 | Data-port write word |
| d_rdata | input | 32 | Data-port read word |
| i_addr | output | 32 | Instruction-port aligned byte address |
| i_re | output | 1 | Instruction-port read strobe |
| i_rdata | input | 32 | Instruction-port aligned word |

## Verification
If a command register is lost or delayed, the strobe for that command appears one cycle late or not at all. The data register or byte buffer is then wrong two cycles after the command. A wrong lane select or a wrong address shift shows up as the wrong byte, or the wrong word, in that same N+2 cycle. A wrong extension shows at once on `mbr_sx` or `mbr_zx`, and is most visible for bytes whose bit 7 is set. A wrong priority on the data register shows only when `ld_mdr` and a read result arrive at the same edge: the bus value then replaces the memory word.

// File: rtl/mbif_pkg.sv
package mbif_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic wr;
    logic rd;
    logic fetch;
  } mem_cmd_t;
endpackage

// File: rtl/mbif_cmd_pipe.sv
module mbif_cmd_pipe
  import mbif_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  mem_cmd_t cmd_in,
  output mem_cmd_t cmd_q
);
  // One stage between the microinstruction and the memory strobes.
  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_in;
  end
endmodule

// File: rtl/mbif_word_port.sv
module mbif_word_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] c_bus,
  input  logic              ld_mar,
  input  logic              ld_mdr,
  input  logic              rd_go,
  input  logic              wr_go,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] addr,
  output logic              re,
  output logic              we,
  output logic [DATA_W-1:0] wdata
);
  localparam int unsigned LANES     = DATA_W / BYTE_W;
  localparam int unsigned LANE_BITS = $clog2(LANES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar <= '0;
      mdr <= '0;
    end else begin
      if (ld_mar) mar <= c_bus;
      // Memory result has priority over a datapath load.
      if (rd_go)       mdr <= rdata;
      else if (ld_mdr) mdr <= c_bus;
    end
  end

  assign addr  = {mar[DATA_W-1-LANE_BITS:0], {LANE_BITS{1'b0}}};
  assign re    = rd_go;
  assign we    = wr_go;
  assign wdata = mdr;
endmodule

// File: rtl/mbif_byte_port.sv
module mbif_byte_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] c_bus,
  input  logic              ld_pc,
  input  logic              fetch_go,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] pc,
  output logic [BYTE_W-1:0] mbr,
  output logic [DATA_W-1:0] addr,
  output logic              re,
  output logic [DATA_W-1:0] zx,
  output logic [DATA_W-1:0] sx
);
  localparam int unsigned LANES     = DATA_W / BYTE_W;
  localparam int unsigned LANE_BITS = $clog2(LANES);

  logic [BYTE_W-1:0] lane [LANES];
  logic [BYTE_W-1:0] picked;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = rdata[g*BYTE_W +: BYTE_W];
  end

  assign picked = lane[pc[LANE_BITS-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= '0;
      mbr <= '0;
    end else begin
      if (ld_pc)    pc  <= c_bus;
      if (fetch_go) mbr <= picked;
    end
  end

  assign addr = {pc[DATA_W-1:LANE_BITS], {LANE_BITS{1'b0}}};
  assign re   = fetch_go;
  assign zx   = {{(DATA_W-BYTE_W){1'b0}}, mbr};
  assign sx   = {{(DATA_W-BYTE_W){mbr[BYTE_W-1]}}, mbr};
endmodule

// File: rtl/mbif_bridge.sv
module mbif_bridge
  import mbif_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned LANE_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] c_bus,
  input  logic              ld_mar,
  input  logic              ld_mdr,
  input  logic              ld_pc,
  input  logic              cmd_wr,
  input  logic              cmd_rd,
  input  logic              cmd_fetch,
  output logic [DATA_W-1:0] mar_q,
  output logic [DATA_W-1:0] mdr_q,
  output logic [DATA_W-1:0] pc_q,
  output logic [LANE_W-1:0] mbr_q,
  output logic [DATA_W-1:0] mbr_zx,
  output logic [DATA_W-1:0] mbr_sx,
  output logic [DATA_W-1:0] d_addr,
  output logic              d_re,
  output logic              d_we,
  output logic [DATA_W-1:0] d_wdata,
  input  logic [DATA_W-1:0] d_rdata,
  output logic [DATA_W-1:0] i_addr,
  output logic              i_re,
  input  logic [DATA_W-1:0] i_rdata
);
  mem_cmd_t cmd_now, cmd_q;

  assign cmd_now = '{wr: cmd_wr, rd: cmd_rd, fetch: cmd_fetch};

  mbif_cmd_pipe u_pipe (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_now), .cmd_q(cmd_q)
  );

  mbif_word_port #(.DATA_W(DATA_W), .BYTE_W(LANE_W)) u_word (
    .clk(clk), .rst_n(rst_n), .c_bus(c_bus),
    .ld_mar(ld_mar), .ld_mdr(ld_mdr),
    .rd_go(cmd_q.rd), .wr_go(cmd_q.wr), .rdata(d_rdata),
    .mar(mar_q), .mdr(mdr_q), .addr(d_addr),
    .re(d_re), .we(d_we), .wdata(d_wdata)
  );

  mbif_byte_port #(.DATA_W(DATA_W), .BYTE_W(LANE_W)) u_byte (
    .clk(clk), .rst_n(rst_n), .c_bus(c_bus), .ld_pc(ld_pc),
    .fetch_go(cmd_q.fetch), .rdata(i_rdata),
    .pc(pc_q), .mbr(mbr_q), .addr(i_addr), .re(i_re),
    .zx(mbr_zx), .sx(mbr_sx)
  );
endmodule

// File: rtl/mbif_checker.sv
module mbif_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] c_bus,
  input logic        ld_mdr,
  input logic        cmd_wr,
  input logic        cmd_rd,
  input logic        cmd_fetch,
  input logic [31:0] mdr_q,
  input logic [31:0] pc_q,
  input logic [7:0]  mbr_q,
  input logic [31:0] mbr_zx,
  input logic [31:0] mbr_sx,
  input logic [31:0] d_addr,
  input logic        d_re,
  input logic        d_we,
  input logic [31:0] d_rdata,
  input logic        i_re,
  input logic [31:0] i_rdata
);
  logic [7:0] want_lane;
  assign want_lane = i_rdata[int'(pc_q[1:0])*8 +: 8];

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    d_addr[1:0] == 2'b00); // R3
  AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |=> d_re); // R4
  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    d_re |=> mdr_q == $past(d_rdata)); // R10
  AST_WR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> d_we); // R5
  AST_FETCH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fetch |=> i_re); // R6
  AST_FETCH_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    i_re |=> mbr_q == $past(want_lane)); // R6
  AST_MBR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !i_re |=> $stable(mbr_q)); // R11
  AST_MDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!d_re && !ld_mdr) |=> $stable(mdr_q)); // R11
  AST_ZX_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    mbr_zx == {24'h0, mbr_q}); // R7
  AST_SX_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    mbr_sx[7:0] == mbr_q && (mbr_sx[31:8] == '0 || mbr_sx[31:8] == '1)
    && mbr_sx[8] == mbr_q[7]); // R8
endmodule

bind mbif_bridge mbif_checker u_chk (
  .clk(clk), .rst_n(rst_n), .c_bus(c_bus), .ld_mdr(ld_mdr),
  .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .cmd_fetch(cmd_fetch),
  .mdr_q(mdr_q), .pc_q(pc_q), .mbr_q(mbr_q), .mbr_zx(mbr_zx),
  .mbr_sx(mbr_sx), .d_addr(d_addr), .d_re(d_re), .d_we(d_we),
  .d_rdata(d_rdata), .i_re(i_re), .i_rdata(i_rdata)
);

// File: tb/test_mbif_bridge.sv
module test_mbif_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] c_bus;
  logic        ld_mar, ld_mdr, ld_pc, cmd_wr, cmd_rd, cmd_fetch;
  logic [31:0] mar_q, mdr_q, pc_q, mbr_zx, mbr_sx;
  logic [7:0]  mbr_q;
  logic [31:0] d_addr, d_wdata, d_rdata, i_addr, i_rdata;
  logic        d_re, d_we, i_re;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mbif_bridge i_mbif_bridge (.*);

  // Behavioural store: 16 words, aliased on address bits 5:2.
  logic [31:0] mem [16];
  assign d_rdata = mem[d_addr[5:2]];
  assign i_rdata = mem[i_addr[5:2]];
  always @(posedge clk) if (d_we) mem[d_addr[5:2]] <= d_wdata;

  function automatic logic [7:0] byte_at(int b);
    return 8'(b * 37 + 3);
  endfunction
  function automatic logic [31:0] word_at(int k);
    return {byte_at(4*k+3), byte_at(4*k+2), byte_at(4*k+1), byte_at(4*k)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    c_bus = '0; ld_mar = 0; ld_mdr = 0; ld_pc = 0;
    cmd_wr = 0; cmd_rd = 0; cmd_fetch = 0;
  endtask

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] mar;
    logic [31:0] exp_iaddr;
    logic [31:0] exp_daddr;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    '{32'h0000_0005, 32'h0000_0002, 32'h0000_0004, 32'h0000_0008},
    '{32'h0000_000A, 32'h0000_0007, 32'h0000_0008, 32'h0000_001C},
    '{32'h0000_0023, 32'h0000_000F, 32'h0000_0020, 32'h0000_003C},
    '{32'h1000_0007, 32'h4000_0003, 32'h1000_0004, 32'h0000_000C},
    '{32'hFFFF_FFFE, 32'hC000_0001, 32'hFFFF_FFFC, 32'h0000_0004}
  };

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0]  eb;
    logic [31:0] old_mdr;
    logic [7:0]  old_mbr;
    for (int k = 0; k < 16; k++) mem[k] = word_at(k);
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mar", mar_q, 0); chk("R1 mdr", mdr_q, 0);
    chk("R1 pc", pc_q, 0);   chk("R1 mbr", {24'h0, mbr_q}, 0);
    chk("R1 strobes", {29'h0, d_re, d_we, i_re}, 0);

    // Table walk: concurrent read and fetch (R2 R3 R4 R6 R7 R8 R9)
    foreach (VEC[v]) begin
      c_bus = VEC[v].pc; ld_pc = 1;
      @(negedge clk); ld_pc = 0; c_bus = VEC[v].mar; ld_mar = 1;
      @(negedge clk); ld_mar = 0;
      chk("R2 pc load", pc_q, VEC[v].pc);
      chk("R2 mar load", mar_q, VEC[v].mar);
      cmd_rd = 1; cmd_fetch = 1;
      old_mdr = mdr_q; old_mbr = mbr_q;
      @(negedge clk); cmd_rd = 0; cmd_fetch = 0;
      chk("R9 strobes", {30'h0, d_re, i_re}, 32'h3);
      chk("R3 d_addr", d_addr, VEC[v].exp_daddr);
      chk("R6 i_addr", i_addr, VEC[v].exp_iaddr);
      chk("R4 mdr still old", mdr_q, old_mdr);
      chk("R11 mbr still old", {24'h0, mbr_q}, {24'h0, old_mbr});
      @(negedge clk);
      eb = byte_at(int'(VEC[v].pc[5:0]));
      chk("R4 mdr word", mdr_q, word_at(int'(VEC[v].mar[3:0])));
      chk("R6 mbr byte", {24'h0, mbr_q}, {24'h0, eb});
      chk("R7 zero ext", mbr_zx, {24'h0, eb});
      chk("R8 sign ext", mbr_sx, {{24{eb[7]}}, eb});
      chk("R11 no strobe", {30'h0, d_re, i_re}, 0);
    end

    // R5 write then read back
    c_bus = 32'h0000_0005; ld_mar = 1;
    @(negedge clk); ld_mar = 0; c_bus = 32'hDEAD_BEEF; ld_mdr = 1;
    @(negedge clk); ld_mdr = 0; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
    chk("R5 we", {31'h0, d_we}, 1);
    chk("R5 wdata", d_wdata, 32'hDEAD_BEEF);
    chk("R5 waddr", d_addr, 32'h14);
    @(negedge clk);
    c_bus = 32'h0; ld_mdr = 1;
    @(negedge clk); ld_mdr = 0;
    chk("R2 mdr load", mdr_q, 0);
    cmd_rd = 1;
    @(negedge clk); cmd_rd = 0;
    @(negedge clk);
    chk("R5 readback", mdr_q, 32'hDEAD_BEEF);

    // R10 collision: read result and ld_mdr at the same edge
    c_bus = 32'h0000_0009; ld_mar = 1;
    @(negedge clk); ld_mar = 0; cmd_rd = 1;
    @(negedge clk); cmd_rd = 0; c_bus = 32'h1234_5678; ld_mdr = 1;
    @(negedge clk); ld_mdr = 0;
    chk("R10 memory wins", mdr_q, word_at(9));

    // R11 ld_pc without fetch leaves mbr alone
    old_mbr = mbr_q;
    c_bus = 32'h0000_0001; ld_pc = 1;
    @(negedge clk); ld_pc = 0;
    @(negedge clk);
    chk("R11 mbr kept", {24'h0, mbr_q}, {24'h0, old_mbr});

    // R1 reset clears loaded state
    rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 re-reset mdr", mdr_q, 0);
    chk("R1 re-reset pc", pc_q, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule